// File: doc/BRIEF.md
# Multiple Header Error Log Queue

This block keeps the record of the first uncorrectable error for the advanced error logging facility of a serial-link function. The record holds a 5-bit pointer to the status bit of that error, its requester identifier, four header words and four prefix words, and a flag that marks the prefix words as valid. An error classifier upstream issues one record request per uncorrectable error. The uncorrectable status register is held by a neighbouring block. It gives this block its current value and a strobe each time software has applied a write-1-to-clear to it.

When multiple header recording is enabled and the status bit that the pointer names is still set, a new error cannot overwrite the log. It goes into a first-in first-out queue of `DEPTH` entries instead. When the queue is full, the error is dropped and an overflow pulse is raised. After software clears the first-error bit, the block asks the status register to set again the bits of every queued error, pops the oldest entry and loads it into the log. If software writes the register while the first-error bit is still set, the same re-set request undoes any queued bit that the write removed. Software signals that the error has been handled by clearing the first-error bit.

Top module: `err_hdr_log_queue`

## Requirements
- R1: During and after reset, `log_fep` is 0 and `log_src_id`, `log_hdr`, `log_pfx`, `log_pfx_valid`, `overflow`, `restore_valid` and `restore_mask` are all zero.
- R2: A record that is not queued loads the log on the clock edge that samples `rec_valid`. `log_fep` becomes the index of the lowest set bit of `rec_status`. `log_src_id` takes `rec_src_id`. `log_hdr` takes `rec_hdr` (word k in bits 32k+31:32k) when `rec_hdr_valid` is 1, and all zeros otherwise.
- R3: On a load, `log_pfx` takes `rec_pfx` and `log_pfx_valid` becomes 1 only when both `rec_pfx_present` and `pfx_en` are 1. Otherwise `log_pfx` is zero and `log_pfx_valid` is 0.
- R4: When recording is enabled (`ctrl_mhr_en`=1 and `DEPTH`>0) and `uncor_status[log_fep]` is 1, a record goes into the queue and the log is left unchanged.
- R5: A record that must be queued while `DEPTH` entries are already waiting is discarded. `overflow` is 1 for exactly the one cycle after that edge.
- R6: A status strobe with `uncor_status[log_fep]`=0, recording enabled and a non-empty queue has three effects on the next cycle. `restore_valid` is 1 with `restore_mask` equal to the OR of the status words of all queued entries, including the one being removed. The oldest entry is removed. The log is loaded from that entry using the rules of R2 and R3, so entries leave in arrival order.
- R7: A status strobe with `uncor_status[log_fep]`=0 and either an empty queue or recording disabled clears the pointer, the source identifier, both logs and the prefix flag.
- R8: A status strobe with `uncor_status[log_fep]`=1, recording enabled and a non-empty queue gives a one-cycle `restore_valid` with `restore_mask` equal to the OR of the queued status words. The log does not change.
- R9: A status strobe with `uncor_status[log_fep]`=1 and recording disabled empties the queue without loading anything.
- R10: `mhr_cap` is 1 exactly when `DEPTH`>0. With `DEPTH`=0, `ctrl_mhr_en` has no effect and every record loads the log.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_mhr_en | input | 1 | Multiple header recording enable from the control register |
| pfx_en | input | 1 | End-to-end prefix support enable from device control 2 |
| uncor_status | input | 32 | Current uncorrectable status register value |
| sts_wr_valid | input | 1 | Strobe: a write-1-to-clear has just been applied to the status register |
| rec_valid | input | 1 | Record request from the classifier (never in the same cycle as `sts_wr_valid`) |
| rec_status | input | 32 | One-hot status bit of the error |
| rec_src_id | input | 16 | Requester identifier of the error |
| rec_hdr_valid | input | 1 | Header words are meaningful |
| rec_pfx_present | input | 1 | Prefix words are present |
| rec_hdr | input | 128 | Four header words |
| rec_pfx | input | 128 | Four prefix words |
| mhr_cap | output | 1 | Multiple header recording capability |
| log_fep | output | 5 | First error pointer |
| log_src_id | output | 16 | Source identifier of the logged error |
| log_hdr | output | 128 | Header log |
| log_pfx | output | 128 | Prefix log |
| log_pfx_valid | output | 1 | Prefix log holds valid words |
| overflow | output | 1 | One-cycle pulse: a record was dropped |
| restore_valid | output | 1 | One-cycle request to OR `restore_mask` into the status register |
| restore_mask | output | 32 | Status bits of the queued errors |

## Verification
The case that is hardest to reach from the ports is a full queue that must then be drained in order. It needs a logged first error whose status bit stays set, four more records, one more that overflows, and then a series of status writes. Each write either keeps or removes the first-error bit, and the bench keeps its own model of the status register between those writes. The flush case is hardest to observe, because an emptied queue produces no output of its own. The bench therefore disables recording and strobes with the first-error bit still set, then enables recording again and clears that bit. The log must clear instead of loading the entry that was left in the queue.

// File: rtl/err_hdr_log_pkg.sv
package err_hdr_log_pkg;

    localparam int STATUS_W = 32;
    localparam int FEP_W    = 5;
    localparam int SRC_W    = 16;
    localparam int WORDS    = 4;

    typedef logic [WORDS-1:0][31:0] quad_t;

    // one error as handed over by the classifier and kept in the queue
    typedef struct packed {
        logic [STATUS_W-1:0] status;
        logic [SRC_W-1:0]    src_id;
        logic                hdr_valid;
        logic                pfx_present;
        quad_t               hdr;
        quad_t               pfx;
    } err_rec_t;

    // visible first-error record
    typedef struct packed {
        logic [FEP_W-1:0] fep;
        logic [SRC_W-1:0] src_id;
        quad_t            hdr;
        quad_t            pfx;
        logic             pfx_valid;
    } log_state_t;

    function automatic logic [FEP_W-1:0] lowest_set(input logic [STATUS_W-1:0] v);
        logic [FEP_W-1:0] idx;
        idx = '0;
        for (int i = STATUS_W - 1; i >= 0; i--) begin
            if (v[i]) idx = FEP_W'(i);
        end
        return idx;
    endfunction

endpackage

// File: rtl/err_hdr_fifo.sv
module err_hdr_fifo
    import err_hdr_log_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                push,
    input  err_rec_t            push_data,
    input  logic                pop,
    input  logic                flush,
    output err_rec_t            head,
    output logic                full,
    output logic                empty,
    output logic [STATUS_W-1:0] status_or
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    err_rec_t         mem [DEPTH];
    logic [DEPTH-1:0] slot_used;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [CNT_W-1:0] count;

    assign full  = (count == CNT_W'(DEPTH));
    assign empty = (count == '0);
    assign head  = mem[rd_ptr];

    always_comb begin
        status_or = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (slot_used[k]) status_or = status_or | mem[k].status;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr    <= '0;
            rd_ptr    <= '0;
            count     <= '0;
            slot_used <= '0;
        end else begin
            if (push && !full) begin
                wr_ptr            <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
                slot_used[wr_ptr] <= 1'b1;
            end
            if (pop && !empty) begin
                rd_ptr            <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
                slot_used[rd_ptr] <= 1'b0;
            end
            case ({push && !full, pop && !empty})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push && !full && !flush) mem[wr_ptr] <= push_data;
    end

endmodule

// File: rtl/err_hdr_log_reg.sv
module err_hdr_log_reg
    import err_hdr_log_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       clear,
    input  err_rec_t   src,
    input  logic       pfx_en,
    output log_state_t state
);
    log_state_t next_state;
    logic       take_pfx;

    always_comb begin
        take_pfx             = src.pfx_present && pfx_en;
        next_state.fep       = lowest_set(src.status);
        next_state.src_id    = src.src_id;
        next_state.hdr       = src.hdr_valid ? src.hdr : '0;
        next_state.pfx       = take_pfx ? src.pfx : '0;
        next_state.pfx_valid = take_pfx;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            state <= '0;
        end else if (load) begin
            state <= next_state;
        end
    end

endmodule

// File: rtl/err_hdr_log_queue.sv
module err_hdr_log_queue
    import err_hdr_log_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ctrl_mhr_en,
    input  logic         pfx_en,
    input  logic [31:0]  uncor_status,
    input  logic         sts_wr_valid,
    input  logic         rec_valid,
    input  logic [31:0]  rec_status,
    input  logic [15:0]  rec_src_id,
    input  logic         rec_hdr_valid,
    input  logic         rec_pfx_present,
    input  logic [127:0] rec_hdr,
    input  logic [127:0] rec_pfx,
    output logic         mhr_cap,
    output logic [4:0]   log_fep,
    output logic [15:0]  log_src_id,
    output logic [127:0] log_hdr,
    output logic [127:0] log_pfx,
    output logic         log_pfx_valid,
    output logic         overflow,
    output logic         restore_valid,
    output logic [31:0]  restore_mask
);
    localparam bit HAS_QUEUE = (DEPTH > 0);

    err_rec_t            incoming, q_head, log_src;
    log_state_t          cur;
    logic                mhr_en, fep_busy;
    logic                queue_it, q_push, q_pop, q_flush, q_full, q_empty;
    logic                load_rec, log_load, log_clear, wr_clear;
    logic [STATUS_W-1:0] q_status_or;

    assign incoming = '{status: rec_status, src_id: rec_src_id,
                        hdr_valid: rec_hdr_valid, pfx_present: rec_pfx_present,
                        hdr: quad_t'(rec_hdr), pfx: quad_t'(rec_pfx)};

    assign mhr_cap  = HAS_QUEUE;
    assign mhr_en   = ctrl_mhr_en && HAS_QUEUE;
    assign fep_busy = uncor_status[cur.fep];

    // record path
    assign queue_it = rec_valid && mhr_en && fep_busy;
    assign q_push   = queue_it && !q_full;
    assign load_rec = rec_valid && !queue_it;

    // status-write path
    assign wr_clear  = sts_wr_valid && !fep_busy;
    assign q_pop     = wr_clear && mhr_en && !q_empty;
    assign log_clear = wr_clear && !q_pop;
    assign q_flush   = sts_wr_valid && fep_busy && !mhr_en;

    assign log_load = load_rec || q_pop;
    assign log_src  = q_pop ? q_head : incoming;

    generate
        if (HAS_QUEUE) begin : g_queue
            err_hdr_fifo #(.DEPTH(DEPTH)) u_fifo (
                .clk       (clk),
                .rst       (rst),
                .push      (q_push),
                .push_data (incoming),
                .pop       (q_pop),
                .flush     (q_flush),
                .head      (q_head),
                .full      (q_full),
                .empty     (q_empty),
                .status_or (q_status_or)
            );
        end else begin : g_no_queue
            assign q_head      = '0;
            assign q_full      = 1'b1;
            assign q_empty     = 1'b1;
            assign q_status_or = '0;
        end
    endgenerate

    err_hdr_log_reg u_log (
        .clk    (clk),
        .rst    (rst),
        .load   (log_load),
        .clear  (log_clear),
        .src    (log_src),
        .pfx_en (pfx_en),
        .state  (cur)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            overflow      <= 1'b0;
            restore_valid <= 1'b0;
            restore_mask  <= '0;
        end else begin
            overflow      <= queue_it && q_full;
            restore_valid <= sts_wr_valid && mhr_en && !q_empty;
            restore_mask  <= (sts_wr_valid && mhr_en && !q_empty) ? q_status_or : '0;
        end
    end

    assign log_fep       = cur.fep;
    assign log_src_id    = cur.src_id;
    assign log_hdr       = cur.hdr;
    assign log_pfx       = cur.pfx;
    assign log_pfx_valid = cur.pfx_valid;

endmodule

// File: rtl/err_hdr_log_queue_chk.sv
module err_hdr_log_queue_chk (
    input logic         clk,
    input logic         rst,
    input logic         rec_valid,
    input logic         sts_wr_valid,
    input logic         mhr_cap,
    input logic [4:0]   log_fep,
    input logic [127:0] log_hdr,
    input logic [127:0] log_pfx,
    input logic         log_pfx_valid,
    input logic         overflow,
    input logic         restore_valid,
    input logic [31:0]  restore_mask
);
    // the log moves only in response to a record or a status write
    assert_quiet_log_R4: assert property (@(posedge clk) disable iff (rst)
        $past(!rec_valid && !sts_wr_valid) |-> ($stable(log_fep) && $stable(log_hdr)));

    // record and status write never share a cycle
    assert_one_event_R4: assert property (@(posedge clk) disable iff (rst)
        !(rec_valid && sts_wr_valid));

    assert_pfx_zero_R3: assert property (@(posedge clk) disable iff (rst)
        !log_pfx_valid |-> (log_pfx == '0));

    assert_overflow_cause_R5: assert property (@(posedge clk) disable iff (rst)
        overflow |-> $past(rec_valid));

    assert_restore_cause_R8: assert property (@(posedge clk) disable iff (rst)
        restore_valid |-> ($past(sts_wr_valid) && mhr_cap));

    assert_restore_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        restore_valid |-> (restore_mask != '0));

endmodule

bind err_hdr_log_queue err_hdr_log_queue_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .rec_valid     (rec_valid),
    .sts_wr_valid  (sts_wr_valid),
    .mhr_cap       (mhr_cap),
    .log_fep       (log_fep),
    .log_hdr       (log_hdr),
    .log_pfx       (log_pfx),
    .log_pfx_valid (log_pfx_valid),
    .overflow      (overflow),
    .restore_valid (restore_valid),
    .restore_mask  (restore_mask)
);

// File: tb/err_hdr_log_queue_bench.sv
module err_hdr_log_queue_bench;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ctrl_mhr_en = 1'b0, pfx_en = 1'b0;
    logic [31:0]  uncor_status = '0, n_status = '0;
    logic         sts_wr_valid = 1'b0, n_wr = 1'b0;
    logic         rec_valid = 1'b0, n_rec = 1'b0;
    logic [31:0]  rec_status = '0;
    logic [15:0]  rec_src_id = '0;
    logic         rec_hdr_valid = 1'b0, rec_pfx_present = 1'b0;
    logic [127:0] rec_hdr = '0, rec_pfx = '0;

    logic         mhr_cap, log_pfx_valid, overflow, restore_valid;
    logic [4:0]   log_fep;
    logic [15:0]  log_src_id;
    logic [127:0] log_hdr, log_pfx;
    logic [31:0]  restore_mask;

    logic         n_cap, n_pv, n_ovf, n_rv;
    logic [4:0]   n_fep;
    logic [15:0]  n_src;
    logic [127:0] n_hdr, n_pfx;
    logic [31:0]  n_mask;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    err_hdr_log_queue #(.DEPTH(4)) u_err_hdr_log_queue (
        .clk(clk), .rst(rst), .ctrl_mhr_en(ctrl_mhr_en), .pfx_en(pfx_en),
        .uncor_status(uncor_status), .sts_wr_valid(sts_wr_valid),
        .rec_valid(rec_valid), .rec_status(rec_status), .rec_src_id(rec_src_id),
        .rec_hdr_valid(rec_hdr_valid), .rec_pfx_present(rec_pfx_present),
        .rec_hdr(rec_hdr), .rec_pfx(rec_pfx), .mhr_cap(mhr_cap),
        .log_fep(log_fep), .log_src_id(log_src_id), .log_hdr(log_hdr),
        .log_pfx(log_pfx), .log_pfx_valid(log_pfx_valid), .overflow(overflow),
        .restore_valid(restore_valid), .restore_mask(restore_mask));

    err_hdr_log_queue #(.DEPTH(0)) u_err_hdr_log_queue_noq (
        .clk(clk), .rst(rst), .ctrl_mhr_en(ctrl_mhr_en), .pfx_en(pfx_en),
        .uncor_status(n_status), .sts_wr_valid(n_wr),
        .rec_valid(n_rec), .rec_status(rec_status), .rec_src_id(rec_src_id),
        .rec_hdr_valid(rec_hdr_valid), .rec_pfx_present(rec_pfx_present),
        .rec_hdr(rec_hdr), .rec_pfx(rec_pfx), .mhr_cap(n_cap),
        .log_fep(n_fep), .log_src_id(n_src), .log_hdr(n_hdr),
        .log_pfx(n_pfx), .log_pfx_valid(n_pv), .overflow(n_ovf),
        .restore_valid(n_rv), .restore_mask(n_mask));

    function automatic logic [127:0] hdr_of(input int idx);
        logic [127:0] v;
        for (int w = 0; w < 4; w++) v[32*w +: 32] = {8'(idx), 8'(w), 16'hC3C3};
        return v;
    endfunction

    function automatic logic [127:0] pfx_of(input int idx);
        logic [127:0] v;
        for (int w = 0; w < 4; w++) v[32*w +: 32] = {8'(idx), 8'(w), 16'h5A5A};
        return v;
    endfunction

    task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // drive one record for 1 clock; outputs are sampled at the following negedge
    task automatic do_rec(input bit noq, input int idx, input bit hv, input bit pp);
        rec_status      = 32'b1 << idx;
        rec_src_id      = 16'(16'h0100 + idx);
        rec_hdr_valid   = hv;
        rec_pfx_present = pp;
        rec_hdr         = hdr_of(idx);
        rec_pfx         = pfx_of(idx);
        if (noq) n_rec = 1'b1; else rec_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        rec_valid = 1'b0;
        n_rec     = 1'b0;
    endtask

    task automatic do_wr(input logic [31:0] sts);
        uncor_status = sts;
        sts_wr_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        sts_wr_valid = 1'b0;
    endtask

    typedef struct packed {
        logic [4:0] idx;
        logic       hv;
        logic       pp;
        logic       pe;
        logic [4:0] efep;
        logic       epv;
    } vec_t;

    localparam vec_t VEC [8] = '{
        '{5'd3,  1'b1, 1'b0, 1'b0, 5'd3,  1'b0},
        '{5'd31, 1'b1, 1'b1, 1'b1, 5'd31, 1'b1},
        '{5'd0,  1'b0, 1'b0, 1'b1, 5'd0,  1'b0},
        '{5'd7,  1'b1, 1'b1, 1'b0, 5'd7,  1'b0},
        '{5'd16, 1'b0, 1'b0, 1'b0, 5'd16, 1'b0},
        '{5'd9,  1'b1, 1'b1, 1'b1, 5'd9,  1'b1},
        '{5'd22, 1'b1, 1'b0, 1'b1, 5'd22, 1'b0},
        '{5'd1,  1'b1, 1'b1, 1'b1, 5'd1,  1'b1}
    };

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state, sampled while reset is held
        check("R1 fep", 128'(log_fep), 0);
        check("R1 hdr", log_hdr, 0);
        check("R1 pfx", log_pfx, 0);
        check("R1 flags", {log_pfx_valid, overflow, restore_valid}, 0);
        check("R1 mask", 128'(restore_mask), 0);
        check("R1 src", 128'(log_src_id), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R10 cap depth4", 128'(mhr_cap), 1);
        check("R10 cap depth0", 128'(n_cap), 0);

        // R2/R3 table: status held at 0, so no record is ever queued
        ctrl_mhr_en = 1'b1;
        for (int v = 0; v < 8; v++) begin
            pfx_en = VEC[v].pe;
            do_rec(1'b0, int'(VEC[v].idx), VEC[v].hv, VEC[v].pp);
            check("R2 fep", 128'(log_fep), 128'(VEC[v].efep));
            check("R2 src", 128'(log_src_id), 128'(16'h0100 + VEC[v].idx));
            check("R2 hdr", log_hdr, VEC[v].hv ? hdr_of(int'(VEC[v].idx)) : '0);
            check("R3 pfx", log_pfx, VEC[v].epv ? pfx_of(int'(VEC[v].idx)) : '0);
            check("R3 pfx valid", 128'(log_pfx_valid), 128'(VEC[v].epv));
        end

        // R7 clear with an empty queue
        do_wr(32'h0);
        check("R7 fep", 128'(log_fep), 0);
        check("R7 hdr", log_hdr, 0);
        check("R7 pfx", {log_pfx_valid, log_pfx}, 0);

        // queue fill: first error bit 5 stays set
        pfx_en = 1'b1;
        uncor_status = 32'h0;
        do_rec(1'b0, 5, 1'b1, 1'b1);
        check("R2 first", 128'(log_fep), 5);
        uncor_status = 32'h0000_0020;
        do_rec(1'b0, 12, 1'b1, 1'b1);
        check("R4 fep kept", 128'(log_fep), 5);
        check("R4 hdr kept", log_hdr, hdr_of(5));
        uncor_status |= 32'h0000_1000;
        do_rec(1'b0, 14, 1'b1, 1'b0);
        uncor_status |= 32'h0000_4000;
        do_rec(1'b0, 16, 1'b0, 1'b0);
        uncor_status |= 32'h0001_0000;
        do_rec(1'b0, 18, 1'b1, 1'b1);
        uncor_status |= 32'h0004_0000;
        check("R5 no overflow at depth", 128'(overflow), 0);
        do_rec(1'b0, 20, 1'b1, 1'b1);
        check("R5 overflow pulse", 128'(overflow), 1);
        check("R4 log after overflow", 128'(log_fep), 5);
        @(negedge clk);
        check("R5 pulse one cycle", 128'(overflow), 0);

        // R8 write that clears bit 12 but keeps the first error bit
        do_wr(32'h0005_4020);
        check("R8 restore valid", 128'(restore_valid), 1);
        check("R8 restore mask", 128'(restore_mask), 128'(32'h0005_5000));
        check("R8 log kept", 128'(log_fep), 5);
        @(negedge clk);
        check("R8 restore pulse", 128'(restore_valid), 0);

        // R6 clear the first error bit: oldest entry (12) promoted
        do_wr(32'h0005_4000);
        check("R6 restore valid", 128'(restore_valid), 1);
        check("R6 restore mask", 128'(restore_mask), 128'(32'h0005_5000));
        check("R6 fep", 128'(log_fep), 12);
        check("R6 hdr", log_hdr, hdr_of(12));
        check("R6 pfx", {log_pfx_valid, log_pfx}, {1'b1, pfx_of(12)});
        do_wr(32'h0005_4000);
        check("R6 order second", 128'(log_fep), 14);
        check("R6 restore mask2", 128'(restore_mask), 128'(32'h0005_4000));
        check("R3 no prefix from entry", 128'(log_pfx_valid), 0);
        do_wr(32'h0005_0000);
        check("R6 order third", 128'(log_fep), 16);
        check("R2 hdr invalid entry", log_hdr, 0);

        // R9 flush with recording disabled, then clear: queued 18 must not appear
        ctrl_mhr_en = 1'b0;
        do_wr(32'h0005_0000);
        check("R9 no restore", 128'(restore_valid), 0);
        check("R9 log kept", 128'(log_fep), 16);
        ctrl_mhr_en = 1'b1;
        do_wr(32'h0004_0000);
        check("R9 queue emptied", 128'(log_fep), 0);
        check("R9 restore after flush", 128'(restore_valid), 0);
        check("R7 hdr cleared", log_hdr, 0);

        // R10 no queue: the enable is ignored, records overwrite
        n_status = 32'h0;
        do_rec(1'b1, 5, 1'b1, 1'b0);
        check("R10 first load", 128'(n_fep), 5);
        n_status = 32'h0000_0020;
        do_rec(1'b1, 9, 1'b1, 1'b0);
        check("R10 overwrite fep", 128'(n_fep), 9);
        check("R10 overwrite hdr", n_hdr, hdr_of(9));
        check("R10 no overflow", 128'(n_ovf), 0);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule